// File: doc/BRIEF.md
# Four-Digit Stopwatch with Range Selection

This block is a stopwatch that counts in steps of ten milliseconds from one fast system clock. Two chained divider stages turn that clock into single-cycle enables. The first enable sets the display scan rate, which is nominally 1 kHz. The second is a tenth of that rate and sets the counting rate, nominally 100 Hz. The elapsed time is held as four two-digit BCD fields: hundredths, seconds, minutes and hours. Each field rolls over into the next one up.

A start input lets the count run. A stop input freezes it in place, and start then continues from the frozen value. A synchronous reset returns everything to zero and leaves the stopwatch paused. The start, stop and range inputs pass through a two-flop synchroniser before they are used.

The display is a four-digit multiplexed seven-segment module. One digit is lit per scan step. A range input picks the pair of fields shown: seconds and hundredths, or hours and minutes. The decimal point separates the two fields.

Top module: `stopwatch_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every field clears to zero and the stopwatch becomes paused. During reset all digit selects and all segments are driven to their inactive level. After release the display reads 00.00 in both views.
- R2: The counting enable occurs exactly once every SCAN_DIV*COUNT_DIV clocks. While running, each enable adds one hundredth. A run window of K*SCAN_DIV*COUNT_DIV clocks therefore adds exactly K.
- R3: A synchronised stop level pauses the count. While paused the count holds its value, and a later start continues from that held value.
- R4: When start and stop are both high in the same cycle, stop wins and the stopwatch stays paused.
- R5: The hundredths field counts 00 to 99. On an enable at 99 it returns to 00 and adds one to seconds.
- R6: Seconds and minutes each count 00 to 59, return to 00 and carry into the next field up. Hours count 00 to 99 and then return to 00 with no further carry.
- R7: With `range_hours` low, the digits from left to right show seconds tens, seconds units, hundredths tens and hundredths units. With `range_hours` high they show hours tens, hours units, minutes tens and minutes units.
- R8: Exactly one digit select is active at a time. `dig_sel[3]` drives the leftmost digit. The scan moves one place to the right on each scan enable and wraps from `dig_sel[0]` back to `dig_sel[3]`.
- R9: Segment bit mapping:
  - Bits 0 to 6 drive segments a to g.
  - Bit 7 drives the decimal point, which lights only on the second digit from the left.
  - Segments use a standard seven-segment decimal font.
  - Both buses are active low by default; parameters set each polarity.
- R10: Asserting reset while the count is running, with start released, clears the count. After release the stopwatch stays paused at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_btn | input | 1 | Start/resume request, level, asynchronous |
| stop_btn | input | 1 | Pause request, level, asynchronous |
| range_hours | input | 1 | 1 shows hours:minutes, 0 shows seconds:hundredths |
| seg_out | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |
| dig_sel | output | 4 | One-hot digit select, bit 3 is the leftmost digit |

## Verification
The bench builds the block with SCAN_DIV=2 and COUNT_DIV=2. The count then advances every four clocks and the scan moves every two. At these values a run of about six thousand hundredths fits easily, so the bench reaches the hundredths carry and the seconds-into-minutes carry. Both display views are read after that run. The polarity parameters stay at their defaults, so the bench checks the active-low encoding. The minutes-into-hours carry and the hours wrap take far longer than any run at these divider values. They are guarded by the in-design properties instead.

// File: rtl/stopwatch_pkg.sv
// Shared types and helpers for the stopwatch.
// Assumes four BCD fields, ordered from least to most significant.
package stopwatch_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int FIELD_W    = 8;
    localparam int NUM_DIGITS = 4;

    typedef logic [FIELD_W-1:0] bcd_pair_t;

    typedef enum logic [1:0] {
        FLD_HUND = 2'd0,
        FLD_SEC  = 2'd1,
        FLD_MIN  = 2'd2,
        FLD_HOUR = 2'd3
    } field_e;

    // Largest tens digit each field may reach before wrapping.
    function automatic int tens_limit(int fld);
        case (fld)
            1, 2:    return 5;
            default: return 9;
        endcase
    endfunction

    // Active-high segment pattern, bit 0 = a ... bit 6 = g.
    function automatic logic [6:0] seg_font(logic [3:0] d);
        case (d)
            4'd0:    return 7'h3F;
            4'd1:    return 7'h06;
            4'd2:    return 7'h5B;
            4'd3:    return 7'h4F;
            4'd4:    return 7'h66;
            4'd5:    return 7'h6D;
            4'd6:    return 7'h7D;
            4'd7:    return 7'h07;
            4'd8:    return 7'h7F;
            4'd9:    return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/sw_sync.sv
// Two-flop synchroniser for a bundle of independent asynchronous levels.
// Assumes each bit is a slow level, such as a button or switch.
module sw_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    // Shift each input through two flops; reset clears both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/sw_div_stage.sv
// One divider stage: emits a one-cycle tick on every N-th cycle with en high.
// Assumes N >= 1. When N is 1 the stage passes en straight through.
module sw_div_stage #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int CW = (N > 1) ? $clog2(N) : 1;

    generate
        if (N == 1) begin : g_pass
            assign tick = en;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            logic          at_end;

            assign at_end = (cnt_q == CW'(N - 1));
            assign tick   = en && at_end;

            // Count enabled cycles, wrapping after N of them.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (en)
                    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
            end

            // R2
            cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CW'(N - 1));
        end
    endgenerate

endmodule

// File: rtl/sw_tick_gen.sv
// Builds the scan enable and the counting enable from the system clock.
// Assumes the counting enable always falls on a scan-enable cycle.
module sw_tick_gen #(
    parameter int SCAN_DIV  = 48000,
    parameter int COUNT_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic scan_tick,
    output logic count_tick
);

    localparam int PERIOD = SCAN_DIV * COUNT_DIV;

    sw_div_stage #(.N(SCAN_DIV)) u_scan_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .tick  (scan_tick)
    );

    sw_div_stage #(.N(COUNT_DIV)) u_count_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (scan_tick),
        .tick  (count_tick)
    );

    // R2
    count_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_tick |-> scan_tick);

    generate
        if (PERIOD > 1) begin : g_space
            // R2
            count_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                count_tick |=> !count_tick);
        end
    endgenerate

endmodule

// File: rtl/sw_run_ctrl.sv
// Run/pause state. Stop wins over start; reset leaves the stopwatch paused.
// Assumes start and stop are already synchronised levels.
module sw_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_s,
    input  logic stop_s,
    output logic run
);

    // Update the run flag from the synchronised controls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (stop_s)
            run <= 1'b0;
        else if (start_s)
            run <= 1'b1;
    end

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> !run);

    // R3
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_s && !stop_s) |=> $stable(run));

endmodule

// File: rtl/sw_bcd_field.sv
// One two-digit BCD field that counts 00 up to {TENS_MAX,9} and then wraps.
// Assumes inc is a single-cycle enable; at_max tells the caller when to carry.
module sw_bcd_field #(
    parameter int TENS_MAX = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    output logic [7:0] value,
    output logic       at_max
);

    logic [3:0] units_q;
    logic [3:0] tens_q;

    assign value  = {tens_q, units_q};
    assign at_max = (tens_q == 4'(TENS_MAX)) && (units_q == 4'd9);

    // Step the units digit, ripple into tens, and wrap at the field limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units_q <= 4'd0;
            tens_q  <= 4'd0;
        end else if (inc) begin
            if (units_q == 4'd9) begin
                units_q <= 4'd0;
                tens_q  <= (tens_q == 4'(TENS_MAX)) ? 4'd0 : tens_q + 4'd1;
            end else begin
                units_q <= units_q + 4'd1;
            end
        end
    end

    // R6
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (units_q <= 4'd9) && (tens_q <= 4'(TENS_MAX)));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max) |=> (value == 8'h00));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(value));

endmodule

// File: rtl/sw_disp_mux.sv
// Scans four seven-segment digits and picks the field pair for the range.
// Assumes fields arrive as packed BCD. Outputs are registered so that the
// segment and select buses always change in the same cycle.
module sw_disp_mux #(
    parameter bit SEG_ACTIVE_LOW = 1'b1,
    parameter bit SEL_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_tick,
    input  logic       show_hours,
    input  logic [7:0] hund,
    input  logic [7:0] secs,
    input  logic [7:0] mins,
    input  logic [7:0] hours,
    output logic [7:0] seg_out,
    output logic [3:0] dig_sel
);

    import stopwatch_pkg::*;

    localparam int         IW      = $clog2(NUM_DIGITS);
    localparam logic [7:0] SEG_OFF = SEG_ACTIVE_LOW ? 8'hFF : 8'h00;
    localparam logic [3:0] SEL_OFF = SEL_ACTIVE_LOW ? 4'hF : 4'h0;

    logic [IW-1:0] pos_q;
    logic [7:0]    left_pair;
    logic [7:0]    right_pair;
    logic [3:0]    nibble;
    logic [7:0]    seg_raw;
    logic [3:0]    sel_raw;

    // Step the scan position on each scan enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (scan_tick)
            pos_q <= pos_q + 1'b1;
    end

    // Choose the field pair and the digit shown at the current position.
    always_comb begin
        left_pair  = show_hours ? hours : secs;
        right_pair = show_hours ? mins  : hund;
        case (pos_q)
            2'd0:    nibble = left_pair[7:4];
            2'd1:    nibble = left_pair[3:0];
            2'd2:    nibble = right_pair[7:4];
            default: nibble = right_pair[3:0];
        endcase
        seg_raw = {(pos_q == 2'd1), seg_font(nibble)};
        sel_raw = 4'b1000 >> pos_q;
    end

    // Register the outputs at the chosen polarity; all dark during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_out <= SEG_OFF;
            dig_sel <= SEL_OFF;
        end else begin
            seg_out <= SEG_ACTIVE_LOW ? ~seg_raw : seg_raw;
            dig_sel <= SEL_ACTIVE_LOW ? ~sel_raw : sel_raw;
        end
    end

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_sel ^ SEL_OFF));

    // R9
    dp_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_out[7] != SEG_OFF[7]) |-> ((dig_sel ^ SEL_OFF) == 4'b0100)));

endmodule

// File: rtl/stopwatch_top.sv
// Stopwatch top level: input synchroniser, enable dividers, run control,
// cascaded BCD fields and display scan.
// Assumes one clock domain and a synchronous active-low reset.
module stopwatch_top #(
    parameter int SCAN_DIV       = 48000,
    parameter int COUNT_DIV      = 10,
    parameter bit SEG_ACTIVE_LOW = 1'b1,
    parameter bit SEL_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_btn,
    input  logic       stop_btn,
    input  logic       range_hours,
    output logic [7:0] seg_out,
    output logic [3:0] dig_sel
);

    import stopwatch_pkg::*;

    logic [2:0]   ctl_s;
    logic         scan_tick;
    logic         count_tick;
    logic         run;
    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] at_max;
    bcd_pair_t    field_q [NUM_FIELDS];

    sw_sync #(.WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({range_hours, stop_btn, start_btn}),
        .q     (ctl_s)
    );

    sw_tick_gen #(.SCAN_DIV(SCAN_DIV), .COUNT_DIV(COUNT_DIV)) u_ticks (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_tick  (scan_tick),
        .count_tick (count_tick)
    );

    sw_run_ctrl u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_s (ctl_s[0]),
        .stop_s  (ctl_s[1]),
        .run     (run)
    );

    assign inc[0] = count_tick && run;

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            sw_bcd_field #(.TENS_MAX(tens_limit(f))) u_field (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc    (inc[f]),
                .value  (field_q[f]),
                .at_max (at_max[f])
            );
            if (f > 0) begin : g_carry
                assign inc[f] = inc[f-1] && at_max[f-1];
            end
        end
    endgenerate

    sw_disp_mux #(
        .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW),
        .SEL_ACTIVE_LOW (SEL_ACTIVE_LOW)
    ) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_tick  (scan_tick),
        .show_hours (ctl_s[2]),
        .hund       (field_q[FLD_HUND]),
        .secs       (field_q[FLD_SEC]),
        .mins       (field_q[FLD_MIN]),
        .hours      (field_q[FLD_HOUR]),
        .seg_out    (seg_out),
        .dig_sel    (dig_sel)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!run && field_q[0] == 8'h00 && field_q[1] == 8'h00
                    && field_q[2] == 8'h00 && field_q[3] == 8'h00));

    // R6
    hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[FLD_HOUR] && at_max[FLD_HOUR]) |=> (field_q[FLD_HOUR] == 8'h00
                                                 && field_q[FLD_MIN] == 8'h00));

    // R2
    paused_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (inc == '0));

endmodule

// File: tb/stopwatch_top_tb.sv
// Scoreboard bench: driver tasks queue expected digit images, a monitor
// matches them against the scanned outputs.
module stopwatch_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SCAN_DIV   = 2;
    localparam int COUNT_DIV  = 2;
    localparam int TICK_P     = SCAN_DIV * COUNT_DIV;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int         idx;
        logic [7:0] seg;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_btn = 1'b0;
    logic       stop_btn = 1'b0;
    logic       range_hours = 1'b0;
    logic [7:0] seg_out;
    logic [3:0] dig_sel;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];

    stopwatch_top #(.SCAN_DIV(SCAN_DIV), .COUNT_DIV(COUNT_DIV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_btn   (start_btn),
        .stop_btn    (stop_btn),
        .range_hours (range_hours),
        .seg_out     (seg_out),
        .dig_sel     (dig_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [6:0] font(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expectation once its digit is being driven.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            if (dig_sel == ~(4'b1000 >> sb_q[0].idx)) begin
                check(seg_out == sb_q[0].seg, sb_q[0].tag, seg_out, sb_q[0].seg);
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: queue the expected image of all four digits, then wait for it.
    task automatic expect_view(input bit hrs, input int left, input int right, input string tag);
        int d[4];
        range_hours = hrs;
        tick(8);
        d[0] = left / 10; d[1] = left % 10; d[2] = right / 10; d[3] = right % 10;
        for (int i = 0; i < 4; i++) begin
            item_t it;
            it.idx = i;
            it.seg = ~{(i == 1), font(d[i])};
            it.tag = (i == 1) ? {tag, "/R9"} : tag;
            sb_q.push_back(it);
        end
        for (int n = 0; n < 1000 && sb_q.size() > 0; n++) @(negedge clk);
        if (sb_q.size() > 0) begin
            check(1'b0, {tag, " scan timeout"}, sb_q.size(), 0);
            sb_q.delete();
        end
        tick(1);
    endtask

    // Run for exactly k counting periods by spacing start and stop pulses.
    task automatic run_for(input int k);
        start_btn = 1'b1;
        tick(1);
        start_btn = 1'b0;
        tick(k * TICK_P - 1);
        stop_btn = 1'b1;
        tick(1);
        stop_btn = 1'b0;
        tick(20);
    endtask

    // Check that the scan steps right one digit at a time and wraps.
    task automatic check_scan_order();
        logic [3:0] prev;
        @(negedge clk);
        prev = ~dig_sel;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (~dig_sel != prev) begin
                logic [3:0] want;
                want = (prev == 4'b0001) ? 4'b1000 : (prev >> 1);
                // R8
                check(~dig_sel == want, "R8 scan order", ~dig_sel, want);
                prev = ~dig_sel;
            end
        end
        tick(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        @(negedge clk);
        // R1: outputs dark during reset
        check(dig_sel == 4'hF, "R1 sel in reset", dig_sel, 4'hF);
        check(seg_out == 8'hFF, "R1 seg in reset", seg_out, 8'hFF);
        tick(1);
        rst_n = 1'b1;
        tick(3);

        expect_view(1'b0, 0, 0, "R1 low view after reset");
        expect_view(1'b1, 0, 0, "R1/R7 high view after reset");

        run_for(37);
        expect_view(1'b0, 0, 37, "R2 count 37");

        tick(200);
        expect_view(1'b0, 0, 37, "R3 held while paused");

        run_for(70);
        expect_view(1'b0, 1, 7, "R3/R5 resume and hundredths carry");

        start_btn = 1'b1;
        stop_btn  = 1'b1;
        tick(1);
        start_btn = 1'b0;
        stop_btn  = 1'b0;
        tick(100);
        expect_view(1'b0, 1, 7, "R4 stop wins");

        run_for(5918);
        expect_view(1'b0, 0, 25, "R6/R7 seconds wrap");
        expect_view(1'b1, 0, 1, "R6/R7 minute carry");

        check_scan_order();

        start_btn = 1'b1;
        tick(1);
        start_btn = 1'b0;
        tick(50);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(100);
        expect_view(1'b0, 0, 0, "R10 reset while running");
        expect_view(1'b1, 0, 0, "R10 reset hours view");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule